// File: doc/BRIEF.md
# Pipelined BF16 Floating-Point Multiplier

This block multiplies two bfloat16 values and returns their bfloat16 product. Each word has one sign bit, an 8-bit biased exponent (bias 127) and 7 stored fraction bits behind an implied leading one. The work is split over two register stages. The first stage combines the signs, sums the exponents and forms the full 16-bit product of the two 8-bit significands. The second stage normalizes that product, rounds it to nearest-even, and then clamps results that fall outside the normal range.

A new operand pair may be presented on every clock cycle. The matching product appears with its own valid flag two rising edges after the pair was sampled. Some cases are outside its scope and are handled in simple fixed ways. Subnormal inputs are flushed to zero. No exception flags are raised. An all-ones exponent field is treated as an ordinary large exponent, so the block never produces infinity or NaN. Overflow saturates to the largest finite magnitude.

Top module: `bf16_pipe_mul`

## Requirements
- R1: The sign bit (bit 15) of every result is the XOR of the two operand sign bits, including zero and saturated results.
- R2: `out_valid` equals the `in_valid` sampled two rising edges earlier. Operand pairs may be issued back to back on consecutive cycles, and each gets its own result.
- R3: For operands with nonzero exponent fields and an in-range result, `out_prod` is the exact product rounded to 7 fraction bits with round-to-nearest, ties-to-even. A rounding carry out of the fraction sets the fraction to zero and adds one to the exponent.
- R4: If the biased result exponent after rounding is 255 or more, the result is the largest finite value: exponent field 0xFE (bits 14:7) and fraction 0x7F (bits 6:0). An operand exponent field of 0xFF is treated as the ordinary value 2^128 times its significand.
- R5: If either operand has an exponent field of 0, the result is a signed zero (bits 14:0 all zero), whatever the fraction bits hold.
- R6: If the biased result exponent after rounding is 0 or less, the result is a signed zero. A result whose rounding carry lifts the exponent from 0 to 1 is returned as the smallest normal value.
- R7: While `rst` is high and on the first cycle after it is released, `out_valid` is 0 and `out_prod` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is valid this cycle |
| in_a | input | 16 | First BF16 operand |
| in_b | input | 16 | Second BF16 operand |
| out_valid | output | 1 | `out_prod` holds a valid product |
| out_prod | output | 16 | BF16 product |

## Verification
The interesting collision is a rounding carry and a range limit acting on the same result. This happens when significands 1.0110101 times 1.0110101 round up to 2.0, while the exponent sum sits right at 254, where the carry forces saturation. It also happens when the sum sits at 0, where the carry rescues an underflow into the smallest normal value. Every exponent pair is swept with that significand pair, and every significand pair is swept at a fixed exponent. Each result is judged against a model that forms the exact product in double precision and rounds its bit pattern to nearest-even. Valid-flag latency is checked under irregular issue gaps.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;

    localparam int EXP_W   = 8;
    localparam int MAN_W   = 7;
    localparam int SIG_W   = MAN_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int WORD_W  = 1 + EXP_W + MAN_W;
    localparam int XEXP_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    localparam logic signed [XEXP_W-1:0] EXP_SAT  = XEXP_W'(EXP_TOP);
    localparam logic signed [XEXP_W-1:0] EXP_BIAS = XEXP_W'(BIAS);

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } bf16_t;

    typedef struct packed {
        logic                     sign;
        logic                     zero;
        logic signed [XEXP_W-1:0] exp;
        logic [PROD_W-1:0]        prod;
    } mul_raw_t;

    function automatic bf16_t signed_zero(input logic s);
        bf16_t r;
        r.sign = s;
        r.exp  = '0;
        r.man  = '0;
        return r;
    endfunction

    function automatic bf16_t max_finite(input logic s);
        bf16_t r;
        r.sign = s;
        r.exp  = EXP_W'(EXP_TOP - 1);
        r.man  = '1;
        return r;
    endfunction

endpackage

// File: rtl/bf16_mul_front.sv
module bf16_mul_front
    import bf16_mul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  bf16_t    op_a,
    input  bf16_t    op_b,
    output logic     s1_valid,
    output mul_raw_t s1_raw
);

    mul_raw_t raw_d;

    always_comb begin
        raw_d.sign = op_a.sign ^ op_b.sign;
        raw_d.zero = (op_a.exp == '0) || (op_b.exp == '0);
        raw_d.exp  = $signed(XEXP_W'(op_a.exp)) + $signed(XEXP_W'(op_b.exp)) - EXP_BIAS;
        raw_d.prod = {1'b1, op_a.man} * {1'b1, op_b.man};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_raw   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_raw   <= raw_d;
        end
    end

endmodule

// File: rtl/bf16_mul_round.sv
module bf16_mul_round
    import bf16_mul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     s1_valid,
    input  mul_raw_t s1_raw,
    output logic     s2_valid,
    output bf16_t    s2_res
);

    logic                     hi;
    logic [PROD_W-2:0]        tail;
    logic [MAN_W-1:0]         keep;
    logic                     guard;
    logic                     sticky;
    logic                     rnd;
    logic [MAN_W:0]           man_r;
    logic signed [XEXP_W-1:0] exp_n;
    logic signed [XEXP_W-1:0] exp_r;
    bf16_t                    res_d;

    always_comb begin
        hi     = s1_raw.prod[PROD_W-1];
        tail   = hi ? s1_raw.prod[PROD_W-2:0] : {s1_raw.prod[PROD_W-3:0], 1'b0};
        keep   = tail[PROD_W-2 -: MAN_W];
        guard  = tail[PROD_W-2-MAN_W];
        sticky = |tail[PROD_W-3-MAN_W:0];
        rnd    = guard & (sticky | keep[0]);
        man_r  = {1'b0, keep} + (MAN_W+1)'(rnd);
        exp_n  = s1_raw.exp + $signed(XEXP_W'(hi));
        exp_r  = exp_n + $signed(XEXP_W'(man_r[MAN_W]));

        if (s1_raw.zero) begin
            res_d = signed_zero(s1_raw.sign);
        end else if (exp_r >= EXP_SAT) begin
            res_d = max_finite(s1_raw.sign);
        end else if (exp_r <= 0) begin
            res_d = signed_zero(s1_raw.sign);
        end else begin
            res_d.sign = s1_raw.sign;
            res_d.exp  = exp_r[EXP_W-1:0];
            res_d.man  = man_r[MAN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_res   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_res   <= res_d;
        end
    end

endmodule

// File: rtl/bf16_pipe_mul.sv
module bf16_pipe_mul
    import bf16_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_prod
);

    bf16_t    op_a;
    bf16_t    op_b;
    logic     s1_valid;
    mul_raw_t s1_raw;
    bf16_t    s2_res;

    assign op_a = in_a;
    assign op_b = in_b;

    bf16_mul_front u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .s1_valid (s1_valid),
        .s1_raw   (s1_raw)
    );

    bf16_mul_round u_round (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_raw   (s1_raw),
        .s2_valid (out_valid),
        .s2_res   (s2_res)
    );

    assign out_prod = s2_res;

endmodule

// File: rtl/bf16_pipe_mul_chk.sv
module bf16_pipe_mul_chk
    import bf16_mul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_prod
);

    logic v1, v2;
    logic s1, s2;
    logic z1, z2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            s1 <= 1'b0; s2 <= 1'b0;
            z1 <= 1'b0; z2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            s1 <= in_a[WORD_W-1] ^ in_b[WORD_W-1];
            s2 <= s1;
            z1 <= (in_a[WORD_W-2 -: EXP_W] == '0) || (in_b[WORD_W-2 -: EXP_W] == '0);
            z2 <= z1;
        end
    end

    // R2
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    // R1
    a_r1_sign_xor: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_prod[WORD_W-1] == s2));

    // R5
    a_r5_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (out_valid && z2) |-> (out_prod[WORD_W-2:0] == '0));

    // R4
    a_r4_no_inf: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_prod[WORD_W-2 -: EXP_W] != '1));

    // R7
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_prod == '0));

endmodule

bind bf16_pipe_mul bf16_pipe_mul_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
);

// File: tb/bf16_pipe_mul_tb.sv
module bf16_pipe_mul_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_valid;
    logic [15:0] out_prod;

    int n_chk  = 0;
    int n_fail = 0;

    logic        h0_v = 1'b0, h1_v = 1'b0;
    logic [15:0] h0_e = '0, h1_e = '0;
    logic [15:0] h0_a = '0, h1_a = '0;
    logic [15:0] h0_b = '0, h1_b = '0;
    string       h0_t = "R3", h1_t = "R3";

    always #10 clk = ~clk;

    bf16_pipe_mul u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // Reference: exact product in double precision, bit pattern rounded to nearest-even.
    function automatic int ref_exp(input logic [15:0] a, input logic [15:0] b,
                                   output logic [6:0] man);
        real         ra, rb;
        logic [63:0] pb;
        logic [44:0] rem;
        logic [7:0]  m8;
        logic        up;
        int          e;
        ra  = $bitstoreal({1'b0, 11'(a[14:7]) + 11'd896, a[6:0], 45'd0});
        rb  = $bitstoreal({1'b0, 11'(b[14:7]) + 11'd896, b[6:0], 45'd0});
        pb  = $realtobits(ra * rb);
        e   = int'(pb[62:52]) - 896;
        rem = pb[44:0];
        up  = (rem > {1'b1, 44'd0}) || ((rem == {1'b1, 44'd0}) && pb[45]);
        m8  = {1'b0, pb[51:45]} + 8'(up);
        if (m8[7]) e = e + 1;
        man = m8[6:0];
        return e;
    endfunction

    task automatic expect_of(input logic [15:0] a, input logic [15:0] b,
                             output logic [15:0] res, output string tag);
        logic       s;
        logic [6:0] m;
        int         e;
        s = a[15] ^ b[15];
        if (a[14:7] == 8'd0 || b[14:7] == 8'd0) begin
            res = {s, 15'd0}; tag = "R5";
        end else begin
            e = ref_exp(a, b, m);
            if (e >= 255) begin
                res = {s, 8'hFE, 7'h7F}; tag = "R4";
            end else if (e <= 0) begin
                res = {s, 15'd0}; tag = "R6";
            end else begin
                res = {s, 8'(e), m}; tag = "R3";
            end
        end
    endtask

    task automatic check_out();
        n_chk++;
        if (out_valid !== h1_v) begin
            n_fail++;
            $display("FAIL R2: out_valid got %b expected %b", out_valid, h1_v);
        end
        if (h1_v) begin
            n_chk++;
            if (out_prod !== h1_e) begin
                n_fail++;
                if (out_prod[15] !== h1_e[15])
                    $display("FAIL R1: a=%h b=%h got %h expected %h", h1_a, h1_b, out_prod, h1_e);
                else
                    $display("FAIL %s: a=%h b=%h got %h expected %h", h1_t, h1_a, h1_b, out_prod, h1_e);
            end
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic v);
        logic [15:0] e;
        string       t;
        @(negedge clk);
        check_out();
        expect_of(a, b, e, t);
        h1_v = h0_v; h1_e = h0_e; h1_a = h0_a; h1_b = h0_b; h1_t = h0_t;
        h0_v = v;    h0_e = e;    h0_a = a;    h0_b = b;    h0_t = t;
        in_valid = v; in_a = a; in_b = b;
    endtask

    function automatic logic [15:0] mk(input logic s, input logic [7:0] e, input logic [6:0] m);
        return {s, e, m};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R7: outputs are clear during reset
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_prod !== 16'h0000) begin
            n_fail++;
            $display("FAIL R7: got v=%b p=%h expected v=0 p=0000", out_valid, out_prod);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_prod !== 16'h0000) begin
            n_fail++;
            $display("FAIL R7: after release got v=%b p=%h expected v=0 p=0000", out_valid, out_prod);
        end

        // Directed corners: R4 and R6 with rounding carry, R5 flush, R4 all-ones exponent
        step(mk(0, 8'd190, 7'h35), mk(0, 8'd191, 7'h35), 1'b1); // R4 via carry
        step(mk(1, 8'd190, 7'h35), mk(0, 8'd190, 7'h35), 1'b1); // R3 exp 254 kept
        step(mk(0, 8'd63,  7'h35), mk(1, 8'd64,  7'h35), 1'b1); // R6 carry to smallest normal
        step(mk(0, 8'd63,  7'h35), mk(0, 8'd63,  7'h35), 1'b1); // R6 underflow
        step(16'h7F7F, 16'hFF7F, 1'b1);                          // R4 negative saturation
        step(mk(1, 8'd0, 7'h55), mk(0, 8'd127, 7'h00), 1'b1);    // R5 nonzero fraction flushed
        step(mk(0, 8'd200, 7'h11), mk(1, 8'd0, 7'h7F), 1'b1);    // R5
        step(16'h7F80, mk(0, 8'd127, 7'h00), 1'b1);              // R4 all-ones exponent
        step(mk(0, 8'd127, 7'h01), mk(0, 8'd127, 7'h01), 1'b1);  // R3
        step(mk(0, 8'd127, 7'h7F), mk(0, 8'd127, 7'h7F), 1'b1);  // R3

        // R3 sweep: every significand pair at unit exponents, signs mixed (R1)
        for (int i = 0; i < 16384; i++) begin
            step(mk(i[3] ^ i[10], 8'd127, i[13:7]), mk(i[5], 8'd127, i[6:0]), 1'b1);
        end

        // R4/R6 sweep: every exponent pair with significand 1.0110101 (carry case)
        for (int i = 0; i < 65536; i++) begin
            step(mk(i[0], i[15:8], 7'h35), mk(i[9], i[7:0], 7'h35), 1'b1);
        end

        // R4/R5/R6 sweep: every exponent pair with varying fractions
        for (int i = 0; i < 65536; i++) begin
            step(mk(i[4], i[15:8], i[6:0] ^ i[14:8]), mk(i[11], i[7:0], i[7:1]), 1'b1);
        end

        // R2: irregular issue pattern with bubbles
        for (int k = 0; k < 300; k++) begin
            logic [15:0] kk;
            kk = 16'(k * 40503);
            step(mk(kk[0], 8'd100 + 8'(kk[5:1]), kk[12:6]),
                 mk(kk[13], 8'd120 + 8'(kk[4:0]), kk[15:9]),
                 (k % 3 != 0) && (k % 7 != 5));
        end

        // drain
        step(16'h0000, 16'h0000, 1'b0);
        step(16'h0000, 16'h0000, 1'b0);
        step(16'h0000, 16'h0000, 1'b0);

        summary();
        $finish;
    end

endmodule